// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Alarm

This block keeps a free-running real-time count that advances once for every programmed number of slow-clock periods. The slow clock is generated and synchronised elsewhere; here it arrives as a one-cycle enable pulse, `tick_i`. A 16-bit prescaler counts these pulses. When it has seen the programmed number of them, it advances a 20-bit counter, which wraps to zero after its maximum value.

Software reaches the block through a plain register port with a combinational read path. There are five registers:

| Address | Register | Access |
|---|---|---|
| 0 | period | read/write |
| 1 | alarm | read/write |
| 2 | current count | read-only |
| 3 | event flags | read, clear-on-read |
| 4 | interrupt enables | read/write |

Two sticky event flags are kept. One records that the counter stepped. The other records that the counter stepped onto the alarm value. Each flag has its own enable bit. The single interrupt line is raised while any flag is set together with its enable.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset, all readable registers (addresses 0, 1, 2, 3 and 4) return zero and `irq_o` is low.
- R2: With a period value N from 1 to 65535 written at address 0, the count at address 2 advances by one on every N-th `tick_i` pulse. Cycles with `tick_i` low do not advance the prescaler or the count.
- R3: A period value of 0 makes one count step take 65536 `tick_i` pulses.
- R4: The count is CNT_W bits wide (20 by default) and steps from its all-ones value to zero.
- R5: A write to address 0 clears both the prescaler and the count. A `tick_i` pulse in the same cycle as that write is discarded.
- R6: Address 2 returns the current count, zero-extended, in the same cycle as the address is presented.
- R7: Flag bit 1 at address 3 is set on every count step. It stays set until the flags are read.
- R8: Flag bit 0 at address 3 is set only in a cycle where the count steps and the new count equals the alarm value at address 1. Writing an alarm value equal to the present count does not set the flag.
- R9: A read (`rd_en` high) at address 3 returns the flags and clears them on the next clock edge. An event in the same cycle as the clearing read leaves its flag set.
- R10: `irq_o` is high exactly when some flag is set and its enable bit at address 4 is set. Enable bit 0 pairs with the alarm flag and enable bit 1 pairs with the step flag.
- R11: Addresses 0, 1 and 4 read back the last written value, truncated to their widths. Writes to addresses 2 and 3 change nothing. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-cycle slow-clock enable pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; only address 3 has a side effect |
| addr | input | 3 | Register address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| irq_o | output | 1 | Interrupt, OR of enabled flags |

## Verification
The hardest state to reach from the ports is the counter wrap. Even with a period of one, the default 20-bit count needs about a million pulses to reach it. The bench therefore drives a second copy built with a 6-bit count alongside the default one, using identical stimulus. That copy wraps after 64 pulses, and its alarm at zero fires on the wrap. Two other cases are hard to hit because they depend on exact timing: a period write that coincides with the final prescaler pulse, and a clearing flag read that coincides with a step. The bench counts pulses so that each of these coincidences lands on the intended edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_AW  = 3;
  localparam int EVT_ALM = 0;
  localparam int EVT_INC = 1;
  localparam int NUM_EVT = 2;

  typedef enum logic [RTC_AW-1:0] {
    REG_PERIOD = 3'd0,
    REG_ALARM  = 3'd1,
    REG_COUNT  = 3'd2,
    REG_FLAGS  = 3'd3,
    REG_ENABLE = 3'd4
  } rtc_reg_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [PRE_W-1:0] period,
  output logic             step
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] last_val;

  // period 0 wraps to all ones, i.e. 2**PRE_W pulses per step
  assign last_val = period - 1'b1;

  always_comb begin
    pre_d = pre_q;
    step  = 1'b0;
    if (clr) begin
      pre_d = '0;
    end else if (tick) begin
      if (pre_q == last_val) begin
        pre_d = '0;
        step  = 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               clr,
  input  logic [CNT_W-1:0]   alarm,
  output logic [CNT_W-1:0]   cnt,
  output logic [NUM_EVT-1:0] evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_inc;
  end

  always_comb begin
    evt          = '0;
    evt[EVT_INC] = step && !clr;
    evt[EVT_ALM] = step && !clr && (cnt_inc == alarm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int PRE_W  = 16,
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [RTC_AW-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [NUM_EVT-1:0] evt,
  output logic [PRE_W-1:0]   period,
  output logic [CNT_W-1:0]   alarm,
  output logic [NUM_EVT-1:0] sts,
  output logic [NUM_EVT-1:0] msk,
  output logic               mode_wr,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);
  localparam int USED_W = (PRE_W > CNT_W) ? PRE_W : CNT_W;

  logic [PRE_W-1:0]   period_q, period_d;
  logic [CNT_W-1:0]   alarm_q, alarm_d;
  logic [NUM_EVT-1:0] sts_q, sts_d;
  logic [NUM_EVT-1:0] msk_q, msk_d;
  logic               wr_alarm, wr_msk, rd_flags;
  logic               unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:USED_W];

  assign mode_wr  = wr_en && (addr == REG_PERIOD);
  assign wr_alarm = wr_en && (addr == REG_ALARM);
  assign wr_msk   = wr_en && (addr == REG_ENABLE);
  assign rd_flags = rd_en && (addr == REG_FLAGS);

  always_comb begin
    period_d = mode_wr  ? wdata[PRE_W-1:0]   : period_q;
    alarm_d  = wr_alarm ? wdata[CNT_W-1:0]   : alarm_q;
    msk_d    = wr_msk   ? wdata[NUM_EVT-1:0] : msk_q;
  end

  // each flag: new event wins over a clearing read
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    assign sts_d[i] = evt[i] | (sts_q[i] & ~rd_flags);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      alarm_q  <= '0;
      sts_q    <= '0;
      msk_q    <= '0;
    end else begin
      period_q <= period_d;
      alarm_q  <= alarm_d;
      sts_q    <= sts_d;
      msk_q    <= msk_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_PERIOD: rdata = DATA_W'(period_q);
      REG_ALARM:  rdata = DATA_W'(alarm_q);
      REG_COUNT:  rdata = DATA_W'(cnt);
      REG_FLAGS:  rdata = DATA_W'(sts_q);
      REG_ENABLE: rdata = DATA_W'(msk_q);
      default:    rdata = '0;
    endcase
  end

  assign irq    = |(sts_q & msk_q);
  assign period = period_q;
  assign alarm  = alarm_q;
  assign sts    = sts_q;
  assign msk    = msk_q;
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_pkg::*;
#(
  parameter int PRE_W  = 16,
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [RTC_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_core_n;
  logic [PRE_W-1:0]   period;
  logic [CNT_W-1:0]   alarm;
  logic [CNT_W-1:0]   rt_cnt;
  logic [NUM_EVT-1:0] evt;
  logic [NUM_EVT-1:0] sts_q;
  logic [NUM_EVT-1:0] msk_q;
  logic               mode_wr;
  logic               step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tick   (tick_i),
    .clr    (mode_wr),
    .period (period),
    .step   (step)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .step  (step),
    .clr   (mode_wr),
    .alarm (alarm),
    .cnt   (rt_cnt),
    .evt   (evt)
  );

  rtc_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .cnt     (rt_cnt),
    .evt     (evt),
    .period  (period),
    .alarm   (alarm),
    .sts     (sts_q),
    .msk     (msk_q),
    .mode_wr (mode_wr),
    .rdata   (rdata),
    .irq     (irq_o)
  );
endmodule

// File: rtl/rtc_alarm_timer_chk.sv
module rtc_alarm_timer_chk
  import rtc_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_i,
  input logic               wr_en,
  input logic               rd_en,
  input logic [RTC_AW-1:0]  addr,
  input logic               irq_o,
  input logic [CNT_W-1:0]   rt_cnt,
  input logic [NUM_EVT-1:0] sts_q,
  input logic [NUM_EVT-1:0] msk_q
);
  logic per_wr, flag_rd;
  assign per_wr  = wr_en && (addr == REG_PERIOD);
  assign flag_rd = rd_en && (addr == REG_FLAGS);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !per_wr) |=> $stable(rt_cnt)); // R2

  AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !per_wr |=> (rt_cnt == $past(rt_cnt) || rt_cnt == CNT_W'($past(rt_cnt) + 1'b1))); // R4

  AST_PERIOD_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr |=> (rt_cnt == '0)); // R5

  AST_STEP_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[EVT_INC] && !flag_rd) |=> sts_q[EVT_INC]); // R7

  AST_ALARM_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !$rose(sts_q[EVT_ALM])); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !tick_i) |=> (sts_q == '0)); // R9

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|msk_q && |sts_q)); // R10
endmodule

bind rtc_alarm_timer rtc_alarm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_core_n),
  .tick_i (tick_i),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .irq_o  (irq_o),
  .rt_cnt (rt_cnt),
  .sts_q  (sts_q),
  .msk_q  (msk_q)
);

// File: tb/sim_rtc_alarm_timer.sv
module sim_rtc_alarm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en(wr), .rd_en(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata0), .irq_o(irq0)
  );

  rtc_alarm_timer #(.CNT_W(6)) u1 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en(wr), .rd_en(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata1), .irq_o(irq1)
  );

  // behavioural reference, index 0 = default copy, 1 = narrow copy
  int m_per[2], m_alm[2], m_msk[2], m_sts[2], m_pre[2], m_cnt[2];
  int m_hold;

  function automatic int lim(input int k);
    return (k == 0) ? (1 << 20) : (1 << 6);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 0;
      for (int k = 0; k < 2; k++) begin
        m_per[k] = 0; m_alm[k] = 0; m_msk[k] = 0;
        m_sts[k] = 0; m_pre[k] = 0; m_cnt[k] = 0;
      end
    end else if (m_hold < 2) begin
      m_hold++;
    end else begin
      for (int k = 0; k < 2; k++) begin
        int span;
        int e;
        span = (m_per[k] == 0) ? 65536 : m_per[k];
        e = 0;
        if (wr && addr == 3'd0) begin
          m_pre[k] = 0;
          m_cnt[k] = 0;
        end else if (tick) begin
          if (m_pre[k] == span - 1) begin
            m_pre[k] = 0;
            m_cnt[k] = (m_cnt[k] + 1) % lim(k);
            e = 2 | ((m_cnt[k] == m_alm[k]) ? 1 : 0);
          end else begin
            m_pre[k]++;
          end
        end
        if (rd && addr == 3'd3) m_sts[k] = 0;
        m_sts[k] = m_sts[k] | e;
        if (wr) begin
          case (addr)
            3'd0: m_per[k] = int'(wdata[15:0]);
            3'd1: m_alm[k] = int'(wdata) & (lim(k) - 1);
            3'd4: m_msk[k] = int'(wdata[1:0]);
            default: ;
          endcase
        end
      end
    end
  end

  function automatic int exp_rd(input int k);
    case (addr)
      3'd0: return m_per[k];
      3'd1: return m_alm[k];
      3'd2: return m_cnt[k];
      3'd3: return m_sts[k];
      3'd4: return m_msk[k];
      default: return 0;
    endcase
  endfunction

  function automatic string addr_tag();
    case (addr)
      3'd2: return "R6";
      3'd3: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the reference on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(addr_tag(), rdata0, 32'(exp_rd(0)));
      chk(addr_tag(), rdata1, 32'(exp_rd(1)));
      chk("R10", {31'd0, irq0}, {31'd0, |(m_sts[0] & m_msk[0])});
      chk("R10", {31'd0, irq1}, {31'd0, |(m_sts[1] & m_msk[1])});
    end
  end

  task automatic drive(input logic w, input logic r, input logic [2:0] a,
                       input logic [31:0] d, input logic t);
    @(posedge clk);
    #1;
    wr = w; rd = r; addr = a; wdata = d; tick = t;
  endtask

  task automatic idle(input logic t);
    drive(1'b0, 1'b0, addr, 32'd0, t);
  endtask

  task automatic put(input logic [2:0] a, input logic [31:0] d);
    drive(1'b1, 1'b0, a, d, 1'b0);
  endtask

  task automatic peek(input logic [2:0] a, input string tag,
                      input logic [31:0] e0, input logic [31:0] e1);
    drive(1'b0, 1'b0, a, 32'd0, 1'b0);
    @(negedge clk);
    chk(tag, rdata0, e0);
    chk(tag, rdata1, e1);
  endtask

  task automatic clear_flags();
    drive(1'b0, 1'b1, 3'd3, 32'd0, 1'b0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    done = 1'b1;
    n_tests++;
    n_fail++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) idle(1'b0);

    // R1: reset state
    for (int a = 0; a < 5; a++) peek(3'(a), "R1", 32'd0, 32'd0);
    chk("R1", {31'd0, irq0}, 32'd0);

    // R2: period 3, pulses every cycle
    put(3'd4, 32'd3);
    put(3'd0, 32'd3);
    put(3'd1, 32'd2);
    repeat (6) idle(1'b1);
    peek(3'd2, "R2", 32'd2, 32'd2);
    peek(3'd3, "R7", 32'd3, 32'd3);
    chk("R8", {31'd0, irq0}, 32'd1);
    // R9: clearing read
    drive(1'b0, 1'b1, 3'd3, 32'd0, 1'b0);
    @(negedge clk);
    chk("R9", rdata0, 32'd3);
    peek(3'd3, "R9", 32'd0, 32'd0);
    chk("R10", {31'd0, irq0}, 32'd0);

    // R2: sparse pulses, gaps do not count
    for (int i = 0; i < 6; i++) begin
      idle(1'b1);
      idle(1'b0);
      idle(1'b0);
    end
    peek(3'd2, "R2", 32'd4, 32'd4);
    peek(3'd3, "R8", 32'd2, 32'd2);

    // R8: alarm written equal to the present count does not flag
    clear_flags();
    put(3'd1, 32'd4);
    idle(1'b0);
    peek(3'd3, "R8", 32'd0, 32'd0);

    // R5: period write coincident with final pulse
    idle(1'b1);
    idle(1'b1);
    drive(1'b1, 1'b0, 3'd0, 32'd3, 1'b1);
    idle(1'b1);
    idle(1'b1);
    peek(3'd2, "R5", 32'd0, 32'd0);
    idle(1'b1);
    peek(3'd2, "R5", 32'd1, 32'd1);

    // R9: step in the same cycle as the clearing read
    clear_flags();
    idle(1'b1);
    idle(1'b1);
    drive(1'b0, 1'b1, 3'd3, 32'd0, 1'b1);
    @(negedge clk);
    chk("R9", rdata0, 32'd0);
    peek(3'd3, "R9", 32'd2, 32'd2);

    // R11: writes to count and flags ignored, readback, unused addresses
    put(3'd2, 32'h55);
    put(3'd3, 32'h0);
    put(3'd5, 32'hFF);
    peek(3'd2, "R11", 32'd2, 32'd2);
    peek(3'd3, "R11", 32'd2, 32'd2);
    peek(3'd0, "R11", 32'd3, 32'd3);
    peek(3'd1, "R11", 32'd4, 32'd4);
    peek(3'd4, "R11", 32'd3, 32'd3);
    peek(3'd5, "R11", 32'd0, 32'd0);
    peek(3'd7, "R11", 32'd0, 32'd0);
    put(3'd1, 32'hFFFF_FFFF);
    peek(3'd1, "R11", 32'hF_FFFF, 32'h3F);

    // R4: wrap of the narrow copy with alarm at zero
    put(3'd0, 32'd1);
    put(3'd1, 32'd0);
    clear_flags();
    repeat (64) idle(1'b1);
    peek(3'd2, "R4", 32'd64, 32'd0);
    peek(3'd3, "R4", 32'd2, 32'd3);

    // R3: period zero means 65536 pulses
    put(3'd0, 32'd0);
    clear_flags();
    repeat (65535) idle(1'b1);
    peek(3'd2, "R3", 32'd0, 32'd0);
    idle(1'b1);
    peek(3'd2, "R3", 32'd1, 32'd1);

    // R10: enable bits pair with their flags
    put(3'd4, 32'd1);
    idle(1'b0);
    @(negedge clk);
    chk("R10", {31'd0, irq0}, 32'd0);
    chk("R10", {31'd0, irq1}, 32'd0);
    put(3'd4, 32'd2);
    idle(1'b0);
    @(negedge clk);
    chk("R10", {31'd0, irq0}, 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule